// File: doc/BRIEF.md
# Correlation Victim Selector

This block decides which way of a set-associative cache set is evicted on a miss. In place of recency or insertion-order state, it keeps one learned weight vector per way for every set. Each request carries a full address. The block takes the tag and set fields from that address and turns the tag bits into a vector of +1 and −1 values. It then forms the inner product of that vector with the weight vector of each way in the addressed set. On a miss with every way occupied, the way with the smallest inner product is named as the victim.

A request also carries a hit flag with the hit way and a mask of empty ways. A hit names the hit way. A miss with an empty way names the lowest-numbered empty way. In both cases the inner products play no part in the choice. After every request, the weight vector of the named way moves one fixed step toward the bipolar tag, and each weight saturates at a symmetric limit.

The inner products are accumulated one tag element per clock. A request is therefore answered after a fixed number of cycles, and the block accepts a new request only when it is idle.

Top module: `corr_victim_sel`

## Requirements
- R1: The address splits into fields as follows: the low log2(WORDS) bits are the word offset, the next log2(SETS) bits are the set index, and the upper TAG_W = ADDR_W − log2(SETS) − log2(WORDS) bits are the tag. Only the set and tag fields affect the result.
- R2: On a miss with `req_empty` all zero, the reported way is the one whose response is smallest. The response is the sum over tag bits of +w for a 1 bit and −w for a 0 bit, where w is that way's weight for that bit position. `vic_kind` is 2 in this case.
- R3: When several ways share the smallest response, the lowest way index is reported.
- R4: On a hit, `vic_way` equals the `req_hit_way` given with the request and `vic_kind` is 0. Neither the responses nor `req_empty` change the choice.
- R5: On a miss with at least one bit of `req_empty` set, the lowest-numbered way whose bit is set is reported and `vic_kind` is 1.
- R6: After reset, every weight is zero, `vic_valid` is low and `req_ready` is high.
- R7: Each set has its own weights. A request to one set never changes the responses seen by another set.
- R8: After each request, every weight of the reported way in the addressed set moves by STEP: up where the tag bit is 1 and down where it is 0. The result is clamped to ±(2^(WGT_W−1) − 1).
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the result is given. `vic_valid` is high for exactly one cycle, starting TAG_W+2 edges after the accepting edge.
- R10: `vic_kind` only ever takes the values 0 (hit), 1 (fill of an empty way) or 2 (learned eviction) while `vic_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Access address |
| req_hit | input | 1 | The access hit in the cache |
| req_hit_way | input | log2(WAYS) | Way that hit |
| req_empty | input | WAYS | One bit per way, set when that way holds no line |
| vic_valid | output | 1 | One-cycle result strobe |
| vic_way | output | log2(WAYS) | Way chosen for this request |
| vic_kind | output | 2 | 0 hit, 1 empty fill, 2 learned eviction |

## Verification
The bench builds the block with an 8-bit address, two sets, two words per line and four ways, which gives a 6-bit tag. It uses an 8-bit weight and a step of 32, so a weight reaches its clamp after only four moves in one direction. This makes saturation and ties easy to produce on purpose.

With these values the bench can sweep every address, in each of the hit, fill and full-miss cases, while its own arithmetic copy of the weights predicts every reported way. Directed sequences on top of the sweep cover three cases:
- all-equal responses, to exercise the tie rule;
- a saturated way that would flip the choice if a weight wrapped;
- training confined to one set, to confirm the other set is unaffected.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [1:0] {
        VK_HIT   = 2'd0,
        VK_FILL  = 2'd1,
        VK_EVICT = 2'd2
    } vkind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_DECIDE,
        ST_UPDATE
    } cvs_state_e;

    // Move a weight one step toward +lim (up) or -lim, clamped.
    function automatic int sat_move(int cur, logic up, int step, int lim);
        int n;
        n = up ? cur + step : cur - step;
        if (n > lim)  n = lim;
        if (n < -lim) n = -lim;
        return n;
    endfunction

    // Accumulator width able to hold +/- nelem*lim.
    function automatic int acc_width(int nelem, int lim);
        return $clog2(nelem * lim + 1) + 2;
    endfunction

endpackage

// File: rtl/cvs_weight_bank.sv
module cvs_weight_bank #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 13,
    parameter int WGT_W = 8,
    parameter int STEP  = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(TAG_W)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [WAYS-1:0][WGT_W-1:0]   rd_wt,
    input  logic                         upd_en,
    input  logic [SET_W-1:0]             upd_set,
    input  logic [WAY_W-1:0]             upd_way,
    input  logic [TAG_W-1:0]             upd_tag
);
    import cvs_pkg::*;

    localparam int WMAX = (1 << (WGT_W - 1)) - 1;

    logic signed [WGT_W-1:0] wts [SETS][WAYS][TAG_W];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_rd
        assign rd_wt[gw] = wts[rd_set][gw][rd_idx];
    end

    for (genvar gs = 0; gs < SETS; gs++) begin : g_set
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
            for (genvar ge = 0; ge < TAG_W; ge++) begin : g_elem
                int nxt;
                always_comb begin
                    nxt = sat_move(int'(wts[gs][gw][ge]), upd_tag[ge], STEP, WMAX);
                end
                always_ff @(posedge clk) begin
                    if (rst) begin
                        wts[gs][gw][ge] <= '0;
                    end else if (upd_en && upd_set == SET_W'(gs) && upd_way == WAY_W'(gw)) begin
                        wts[gs][gw][ge] <= nxt[WGT_W-1:0];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cvs_mac.sv
module cvs_mac #(
    parameter int WAYS  = 4,
    parameter int WGT_W = 8,
    parameter int ACC_W = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        en,
    input  logic                        tag_bit,
    input  logic [WAYS-1:0][WGT_W-1:0]  wt,
    output logic [WAYS-1:0][ACC_W-1:0]  acc
);
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic signed [ACC_W-1:0] term;
        logic signed [ACC_W-1:0] sum_q;
        always_comb begin
            term = {{(ACC_W - WGT_W){wt[gw][WGT_W-1]}}, wt[gw]};
            if (!tag_bit) term = -term;
        end
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                sum_q <= '0;
            end else if (en) begin
                sum_q <= sum_q + term;
            end
        end
        assign acc[gw] = sum_q;
    end

endmodule

// File: rtl/cvs_pick.sv
module cvs_pick #(
    parameter int WAYS  = 4,
    parameter int ACC_W = 14,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        hit,
    input  logic [WAY_W-1:0]            hit_way,
    input  logic [WAYS-1:0]             empty,
    input  logic [WAYS-1:0][ACC_W-1:0]  acc,
    output logic [WAY_W-1:0]            way,
    output cvs_pkg::vkind_e             kind
);
    import cvs_pkg::*;

    logic [WAY_W-1:0]        empty_way;
    logic [WAY_W-1:0]        min_way;
    logic signed [ACC_W-1:0] min_val;

    always_comb begin
        empty_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (empty[i]) empty_way = WAY_W'(i);
        end
    end

    always_comb begin
        min_way = '0;
        min_val = $signed(acc[0]);
        for (int i = 1; i < WAYS; i++) begin
            if ($signed(acc[i]) < min_val) begin
                min_way = WAY_W'(i);
                min_val = $signed(acc[i]);
            end
        end
    end

    always_comb begin
        if (hit) begin
            way  = hit_way;
            kind = VK_HIT;
        end else if (|empty) begin
            way  = empty_way;
            kind = VK_FILL;
        end else begin
            way  = min_way;
            kind = VK_EVICT;
        end
    end

endmodule

// File: rtl/corr_victim_sel.sv
module corr_victim_sel #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WORDS  = 2,
    parameter int WAYS   = 4,
    parameter int WGT_W  = 8,
    parameter int STEP   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hit,
    input  logic [WAY_W-1:0]  req_hit_way,
    input  logic [WAYS-1:0]   req_empty,
    output logic              vic_valid,
    output logic [WAY_W-1:0]  vic_way,
    output logic [1:0]        vic_kind
);
    import cvs_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int IDX_W = $clog2(TAG_W);
    localparam int WMAX  = (1 << (WGT_W - 1)) - 1;
    localparam int ACC_W = acc_width(TAG_W, WMAX);

    cvs_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [SET_W-1:0]  set_q;
    logic              hit_q;
    logic [WAY_W-1:0]  hit_way_q;
    logic [WAYS-1:0]   empty_q;
    logic [WAY_W-1:0]  ch_way_q;
    vkind_e            ch_kind_q;
    logic              vic_valid_q;
    logic [WAY_W-1:0]  vic_way_q;
    vkind_e            vic_kind_q;

    logic                        accept;
    logic [WAYS-1:0][WGT_W-1:0]  rd_wt;
    logic [WAYS-1:0][ACC_W-1:0]  acc;
    logic [WAY_W-1:0]            pick_way;
    vkind_e                      pick_kind;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            idx_q       <= '0;
            tag_q       <= '0;
            set_q       <= '0;
            hit_q       <= 1'b0;
            hit_way_q   <= '0;
            empty_q     <= '0;
            ch_way_q    <= '0;
            ch_kind_q   <= VK_HIT;
            vic_valid_q <= 1'b0;
            vic_way_q   <= '0;
            vic_kind_q  <= VK_HIT;
        end else begin
            vic_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tag_q     <= req_addr[ADDR_W-1 -: TAG_W];
                        set_q     <= req_addr[OFF_W +: SET_W];
                        hit_q     <= req_hit;
                        hit_way_q <= req_hit_way;
                        empty_q   <= req_empty;
                        idx_q     <= '0;
                        st_q      <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (idx_q == IDX_W'(TAG_W - 1)) begin
                        st_q <= ST_DECIDE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    ch_way_q  <= pick_way;
                    ch_kind_q <= pick_kind;
                    st_q      <= ST_UPDATE;
                end
                ST_UPDATE: begin
                    vic_valid_q <= 1'b1;
                    vic_way_q   <= ch_way_q;
                    vic_kind_q  <= ch_kind_q;
                    st_q        <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    cvs_weight_bank #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .WGT_W(WGT_W), .STEP(STEP)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (set_q),
        .rd_idx  (idx_q),
        .rd_wt   (rd_wt),
        .upd_en  (st_q == ST_UPDATE),
        .upd_set (set_q),
        .upd_way (ch_way_q),
        .upd_tag (tag_q)
    );

    cvs_mac #(
        .WAYS(WAYS), .WGT_W(WGT_W), .ACC_W(ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .en      (st_q == ST_ACC),
        .tag_bit (tag_q[idx_q]),
        .wt      (rd_wt),
        .acc     (acc)
    );

    cvs_pick #(
        .WAYS(WAYS), .ACC_W(ACC_W)
    ) u_pick (
        .hit     (hit_q),
        .hit_way (hit_way_q),
        .empty   (empty_q),
        .acc     (acc),
        .way     (pick_way),
        .kind    (pick_kind)
    );

    assign vic_valid = vic_valid_q;
    assign vic_way   = vic_way_q;
    assign vic_kind  = vic_kind_q;

endmodule

// File: rtl/corr_victim_sel_chk.sv
module corr_victim_sel_chk #(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WORDS  = 2,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_hit,
    input logic [WAY_W-1:0] req_hit_way,
    input logic [WAYS-1:0]  req_empty,
    input logic             vic_valid,
    input logic [WAY_W-1:0] vic_way,
    input logic [1:0]       vic_kind
);
    localparam int TAG_W = ADDR_W - $clog2(SETS) - $clog2(WORDS);
    localparam int CNT_W = $clog2(TAG_W + 4) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             hit_l;
    logic [WAY_W-1:0] hw_l;
    logic [WAYS-1:0]  em_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            hit_l <= 1'b0;
            hw_l  <= '0;
            em_l  <= '0;
        end else if (req_valid && req_ready) begin
            cnt_q <= CNT_W'(1);
            hit_l <= req_hit;
            hw_l  <= req_hit_way;
            em_l  <= req_empty;
        end else if (vic_valid) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the strobe comes exactly TAG_W+2 edges after acceptance
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> (cnt_q == CNT_W'(TAG_W + 3)));

    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        vic_valid |=> !vic_valid);

    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r4_hit_way: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && vic_kind == 2'd0) |-> (hit_l && vic_way == hw_l));

    a_r5_lowest_empty: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && vic_kind == 2'd1) |->
            (!hit_l && em_l[vic_way] && ((em_l & ~({WAYS{1'b1}} << vic_way)) == '0)));

    a_r2_full_miss: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && vic_kind == 2'd2) |-> (!hit_l && em_l == '0));

    a_r10_kind_code: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> (vic_kind != 2'd3));

endmodule

bind corr_victim_sel corr_victim_sel_chk #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .WAYS(WAYS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_hit     (req_hit),
    .req_hit_way (req_hit_way),
    .req_empty   (req_empty),
    .vic_valid   (vic_valid),
    .vic_way     (vic_way),
    .vic_kind    (vic_kind)
);

// File: tb/corr_victim_sel_tb.sv
module corr_victim_sel_tb;
    localparam int ADDR_W = 8;
    localparam int SETS   = 2;
    localparam int WORDS  = 2;
    localparam int WAYS   = 4;
    localparam int WGT_W  = 8;
    localparam int STEP   = 32;
    localparam int TAG_W  = ADDR_W - 2;
    localparam int WMAX   = 127;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              req_hit;
    logic [1:0]        req_hit_way;
    logic [WAYS-1:0]   req_empty;
    logic              vic_valid;
    logic [1:0]        vic_way;
    logic [1:0]        vic_kind;

    int total = 0;
    int bad   = 0;
    int mw [SETS][WAYS][TAG_W];

    corr_victim_sel #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .WAYS(WAYS),
        .WGT_W(WGT_W), .STEP(STEP)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_hit(req_hit), .req_hit_way(req_hit_way),
        .req_empty(req_empty), .vic_valid(vic_valid), .vic_way(vic_way),
        .vic_kind(vic_kind)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int resp(int s, int w, int tag);
        int sum = 0;
        for (int e = 0; e < TAG_W; e++)
            sum += ((tag >> e) & 1) ? mw[s][w][e] : -mw[s][w][e];
        return sum;
    endfunction

    task automatic do_req(input int addr, input bit hit, input int hw,
                          input int em, input string tagname);
        int s, tag, ew, ek, best, n;
        s   = (addr / WORDS) % SETS;
        tag = addr / (WORDS * SETS);
        if (hit) begin
            ew = hw; ek = 0;
        end else if (em != 0) begin
            ek = 1; ew = 0;
            for (int i = WAYS - 1; i >= 0; i--) if ((em >> i) & 1) ew = i;
        end else begin
            ek = 2; ew = 0; best = resp(s, 0, tag);
            for (int i = 1; i < WAYS; i++)
                if (resp(s, i, tag) < best) begin best = resp(s, i, tag); ew = i; end
        end
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = ADDR_W'(addr);
        req_hit     = hit;
        req_hit_way = 2'(hw);
        req_empty   = WAYS'(em);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy", int'(req_ready), 0);
        n = 1;
        while (!vic_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == TAG_W + 3, "R9 latency", n, TAG_W + 3);
        chk(int'(vic_way) == ew, tagname, int'(vic_way), ew);
        chk(int'(vic_kind) == ek, "R10 kind", int'(vic_kind), ek);
        @(negedge clk);
        chk(vic_valid == 1'b0, "R9 pulse", int'(vic_valid), 0);
        for (int e = 0; e < TAG_W; e++) begin
            int v;
            v = ((tag >> e) & 1) ? mw[s][ew][e] + STEP : mw[s][ew][e] - STEP;
            if (v > WMAX) v = WMAX;
            if (v < -WMAX) v = -WMAX;
            mw[s][ew][e] = v;
        end
    endtask

    function automatic int mk(int tag, int s, int w);
        return (tag << 2) | (s << 1) | w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                for (int e = 0; e < TAG_W; e++) mw[s][w][e] = 0;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_hit = 1'b0;
        req_hit_way = '0; req_empty = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready", int'(req_ready), 1);
        chk(vic_valid == 1'b0, "R6 valid", int'(vic_valid), 0);

        // all-zero weights: every response ties, way 0 wins
        do_req(mk(6'b101010, 0, 1), 0, 0, 0, "R3 tie");
        // set 1 still untrained despite set 0 training
        do_req(mk(6'b101010, 1, 0), 0, 0, 0, "R7 isolation");
        // drive set1 way2 to the clamp
        for (int k = 0; k < 5; k++) do_req(mk(6'b111111, 1, 0), 1, 2, 4'b0101, "R4 hit");
        // a wrapped weight would turn way2 negative and win here
        do_req(mk(6'b111111, 1, 1), 0, 0, 0, "R8 saturate");
        do_req(mk(6'b000000, 1, 0), 0, 0, 0, "R2 min");
        do_req(mk(6'b010011, 0, 0), 0, 0, 4'b1100, "R5 empty");
        do_req(mk(6'b010011, 0, 1), 0, 0, 4'b1010, "R5 empty");
        // word offset differs only: result follows tag and set
        do_req(mk(6'b110001, 0, 0), 0, 0, 0, "R1 fields");
        do_req(mk(6'b110001, 0, 1), 0, 0, 0, "R1 fields");

        for (int n = 0; n < 256; n++) begin
            int md;
            md = n % 5;
            if (md == 0)      do_req(n, 1, n % 4, (n * 3) % 16, "R4 sweep");
            else if (md == 1) do_req(n, 0, 0, (n * 7) % 16,
                                     ((n * 7) % 16) != 0 ? "R5 sweep" : "R2 sweep");
            else              do_req(n, 0, 0, 0, "R2 sweep");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule